// File: doc/BRIEF.md
# Interrupt Vector Target Generator

This block turns an interrupt request that has already won arbitration into the place where the CPU should start executing. It takes the winner's vector number, priority level (0..15) and group level (0..7). It returns three things: a 24-bit entry address, a flag that tells whether the address came from a preloaded fast-entry pair or from the vector table, and a 2-bit register-bank choice.

Table targets are the programmed table base plus the vector number scaled by a programmable per-entry spacing. For requests at priority 12 to 15, one of two fast-entry pairs can supply the whole address directly, so the table is bypassed. The bank choice is looked up by group and level, and it tells the core whether a global context switch is needed or a local bank can be used.

A request is taken on a valid/ready handshake. The result appears as a one-cycle pulse two clock edges after acceptance. While a request is in flight, ready is low. Configuration is written through a small word-wide write port. All addresses below are byte addresses, and one word is two bytes.

Top module: `irq_tgt_top`

## Requirements
- R1: After synchronous reset, req_ready is 1 and res_valid is 0, and all configuration is zero: spacing code 0, table base 0, both fast pairs disabled, every bank field global.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. req_ready is 0 for exactly the following cycle. res_valid is 1 for exactly one cycle, starting at the second rising edge after acceptance, and req_ready returns to 1 in that same cycle.
- R3: Configuration address 0 bits [1:0] hold the spacing code: 0, 1, 2 and 3 select 2, 4, 8 and 16 words per entry. Address 1 holds table base bits [15:0] and address 2 bits [7:0] hold base bits [23:16]. A table target equals base + vector × spacing × 2.
- R4: The table sum is a full 24-bit addition, so it carries from the low 16 bits into the segment byte and wraps modulo 2^24.
- R5: A fast pair is a segment register and an offset register: pair 0 at addresses 3 and 4, pair 1 at addresses 5 and 6. In the segment register, bit 15 enables the pair, bits [14:13] hold the level minus 12, bits [12:10] hold the group, and bits [7:0] hold the segment. When an enabled pair's level and group both equal the request's, the target is {segment, offset} and res_fast is 1.
- R6: When both pairs match, pair 0 supplies the target.
- R7: When no enabled pair matches, the target comes from the table and res_fast is 0. This covers a disabled pair, a level mismatch, a group mismatch, and every level below 12.
- R8: The bank register for group g is at address 8+g. Bits [2(L−12)+1 : 2(L−12)] are the field for level L in 12..15. res_bank is 00 (global) for field 00 or 01, 10 (local 1) for field 10, and 11 (local 2) for field 11.
- R9: A request with level below 12 always gives res_bank 00, whatever the bank registers hold.
- R10: A configuration write on the same edge as the acceptance is used for that request. A write on the edge that produces the result is not used for it.
- R11: A req_valid held while req_ready is 0 is ignored and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 1 | Winning request present |
| req_ready | output | 1 | Block can accept a request |
| req_vector | input | 8 | Vector number of the request |
| req_level | input | 4 | Priority level 0..15 |
| req_group | input | 3 | Group level 0..7 |
| res_valid | output | 1 | Result pulse |
| res_addr | output | 24 | Entry target address |
| res_fast | output | 1 | 1 when the target came from a fast-entry pair |
| res_bank | output | 2 | 00 global, 10 local bank 1, 11 local bank 2 |

## Verification
A configuration write and a request acceptance can happen on the same edge. A write can also land on the edge where the in-flight request's result is registered. The bench provokes both. It drives a table-base write together with req_valid, then changes the base again one cycle later. The emitted address must reflect the first write and ignore the second. Back-pressure is checked the same way: req_valid is held through the busy cycle, and the bench confirms that no second pulse appears.

// File: rtl/irq_tgt_pkg.sv
// Shared types and constants for the interrupt target generator.
// Assumes 24-bit byte addresses made of an 8-bit segment and a 16-bit offset.
package irq_tgt_pkg;

    localparam int ADDR_W      = 24;
    localparam int SEG_W       = 8;
    localparam int OFF_W       = 16;
    localparam int LEVEL_W     = 4;
    localparam int GROUP_W     = 3;
    localparam logic [3:0] FAST_MIN_LEVEL = 4'd12;

    typedef enum logic [1:0] {
        BANK_GLOBAL = 2'b00,
        BANK_RSVD   = 2'b01,
        BANK_LOCAL1 = 2'b10,
        BANK_LOCAL2 = 2'b11
    } bank_e;

    typedef struct packed {
        logic              en;
        logic [1:0]        lvl;   // level minus 12
        logic [GROUP_W-1:0] grp;
        logic [SEG_W-1:0]  seg;
        logic [OFF_W-1:0]  off;
    } fast_pair_t;

endpackage

// File: rtl/irq_tgt_cfg.sv
// Configuration register file: spacing code, table base, fast-entry pairs
// and per-group bank fields. Assumes NUM_FAST <= 2 so the pairs fit below
// the bank registers in the 16-entry map. Write-only; all fields reset to 0.
module irq_tgt_cfg
    import irq_tgt_pkg::*;
#(
    parameter int NUM_FAST   = 2,
    parameter int NUM_GROUPS = 8,
    parameter int CFG_AW     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [CFG_AW-1:0]             cfg_addr,
    input  logic [15:0]                   cfg_wdata,
    output logic [1:0]                    spacing_sel,
    output logic [ADDR_W-1:0]             tbl_base,
    output fast_pair_t [NUM_FAST-1:0]     fast_cfg,
    output logic [NUM_GROUPS-1:0][7:0]    bank_cfg
);

    localparam int SPACING_ADDR = 0;
    localparam int BASE_LO_ADDR = 1;
    localparam int BASE_HI_ADDR = 2;
    localparam int FAST_BASE    = 3;
    localparam int BANK_BASE    = 8;

    // Spacing code and table base registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spacing_sel <= '0;
            tbl_base    <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_AW'(SPACING_ADDR)) spacing_sel <= cfg_wdata[1:0];
            if (cfg_addr == CFG_AW'(BASE_LO_ADDR)) tbl_base[OFF_W-1:0] <= cfg_wdata;
            if (cfg_addr == CFG_AW'(BASE_HI_ADDR)) tbl_base[ADDR_W-1:OFF_W] <= cfg_wdata[SEG_W-1:0];
        end
    end

    for (genvar i = 0; i < NUM_FAST; i++) begin : g_fast
        localparam int SEG_ADDR = FAST_BASE + 2 * i;
        localparam int OFF_ADDR = FAST_BASE + 2 * i + 1;
        // Fast-entry pair i: control/segment word and offset word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fast_cfg[i] <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == CFG_AW'(SEG_ADDR)) begin
                    fast_cfg[i].en  <= cfg_wdata[15];
                    fast_cfg[i].lvl <= cfg_wdata[14:13];
                    fast_cfg[i].grp <= cfg_wdata[12:10];
                    fast_cfg[i].seg <= cfg_wdata[SEG_W-1:0];
                end
                if (cfg_addr == CFG_AW'(OFF_ADDR)) fast_cfg[i].off <= cfg_wdata;
            end
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
        localparam int B_ADDR = BANK_BASE + g;
        // Bank-field register for group g (four 2-bit level fields).
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_cfg[g] <= '0;
            end else if (cfg_we && cfg_addr == CFG_AW'(B_ADDR)) begin
                bank_cfg[g] <= cfg_wdata[7:0];
            end
        end
    end

endmodule

// File: rtl/irq_tgt_fast.sv
// Fast-entry matcher: compares each enabled pair's level and group with the
// request and returns the lowest-index hit. A pair can only name levels
// 12..15, so lower levels never hit.
module irq_tgt_fast
    import irq_tgt_pkg::*;
#(
    parameter int NUM_FAST = 2
) (
    input  fast_pair_t [NUM_FAST-1:0] fast_cfg,
    input  logic [LEVEL_W-1:0]        level,
    input  logic [GROUP_W-1:0]        group,
    output logic                      hit,
    output logic [ADDR_W-1:0]         addr
);

    logic [NUM_FAST-1:0] match;

    for (genvar i = 0; i < NUM_FAST; i++) begin : g_match
        assign match[i] = fast_cfg[i].en
                        && (level == {2'b11, fast_cfg[i].lvl})
                        && (group == fast_cfg[i].grp);
    end

    // Priority pick: scan from the top so the lowest index wins last.
    always_comb begin
        hit  = 1'b0;
        addr = '0;
        for (int i = NUM_FAST - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit  = 1'b1;
                addr = {fast_cfg[i].seg, fast_cfg[i].off};
            end
        end
    end

endmodule

// File: rtl/irq_tgt_bank.sv
// Bank lookup: selects the 2-bit field for (group, level) when the level is
// 12 or above. The reserved code and all lower levels map to the global bank.
module irq_tgt_bank
    import irq_tgt_pkg::*;
#(
    parameter int NUM_GROUPS = 8
) (
    input  logic [NUM_GROUPS-1:0][7:0] bank_cfg,
    input  logic [LEVEL_W-1:0]         level,
    input  logic [GROUP_W-1:0]         group,
    output bank_e                      bank
);

    logic [7:0] grp_word;
    logic [1:0] field;

    assign grp_word = bank_cfg[group];
    assign field    = grp_word[{level[1:0], 1'b0} +: 2];

    // Map the raw field to a bank, folding the reserved code to global.
    always_comb begin
        if (level < FAST_MIN_LEVEL) begin
            bank = BANK_GLOBAL;
        end else begin
            unique case (field)
                2'b10:   bank = BANK_LOCAL1;
                2'b11:   bank = BANK_LOCAL2;
                default: bank = BANK_GLOBAL;
            endcase
        end
    end

endmodule

// File: rtl/irq_tgt_table.sv
// Vector-table target: base + vector scaled by 2/4/8/16 words (4..32 bytes).
// Assumes byte addressing; the 24-bit sum wraps modulo 2^24.
module irq_tgt_table
    import irq_tgt_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [1:0]        spacing_sel,
    input  logic [VEC_W-1:0]  vector,
    output logic [ADDR_W-1:0] addr
);

    localparam int BYTE_SHIFT_MIN = 2;   // 2 words = 4 bytes

    logic [ADDR_W-1:0] scaled;

    assign scaled = ADDR_W'(vector) << (BYTE_SHIFT_MIN + int'(spacing_sel));
    assign addr   = tbl_base + scaled;

endmodule

// File: rtl/irq_tgt_top.sv
// Interrupt target generator top. Captures one request per handshake,
// computes the table or fast-entry target and the bank choice from the
// current configuration, and registers the result two edges after accept.
// Assumes the request fields are stable while req_valid is high.
module irq_tgt_top
    import irq_tgt_pkg::*;
#(
    parameter int VEC_W      = 8,
    parameter int NUM_FAST   = 2,
    parameter int NUM_GROUPS = 8,
    parameter int CFG_AW     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [15:0]          cfg_wdata,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [VEC_W-1:0]     req_vector,
    input  logic [LEVEL_W-1:0]   req_level,
    input  logic [GROUP_W-1:0]   req_group,
    output logic                 res_valid,
    output logic [ADDR_W-1:0]    res_addr,
    output logic                 res_fast,
    output logic [1:0]           res_bank
);

    logic [1:0]                  spacing_sel;
    logic [ADDR_W-1:0]           tbl_base;
    fast_pair_t [NUM_FAST-1:0]   fast_cfg;
    logic [NUM_GROUPS-1:0][7:0]  bank_cfg;

    logic                  s1_valid;
    logic [VEC_W-1:0]      s1_vector;
    logic [LEVEL_W-1:0]    s1_level;
    logic [GROUP_W-1:0]    s1_group;

    logic                  fast_hit;
    logic [ADDR_W-1:0]     fast_addr;
    logic [ADDR_W-1:0]     tbl_addr;
    bank_e                 bank_sel;
    logic                  accept;

    assign req_ready = !s1_valid;
    assign accept    = req_valid && req_ready;

    irq_tgt_cfg #(
        .NUM_FAST(NUM_FAST), .NUM_GROUPS(NUM_GROUPS), .CFG_AW(CFG_AW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .spacing_sel(spacing_sel), .tbl_base(tbl_base),
        .fast_cfg(fast_cfg), .bank_cfg(bank_cfg)
    );

    irq_tgt_fast #(.NUM_FAST(NUM_FAST)) u_fast (
        .fast_cfg(fast_cfg), .level(s1_level), .group(s1_group),
        .hit(fast_hit), .addr(fast_addr)
    );

    irq_tgt_table #(.VEC_W(VEC_W)) u_table (
        .tbl_base(tbl_base), .spacing_sel(spacing_sel),
        .vector(s1_vector), .addr(tbl_addr)
    );

    irq_tgt_bank #(.NUM_GROUPS(NUM_GROUPS)) u_bank (
        .bank_cfg(bank_cfg), .level(s1_level), .group(s1_group),
        .bank(bank_sel)
    );

    // Stage 1: hold the accepted request for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_vector <= '0;
            s1_level  <= '0;
            s1_group  <= '0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_vector <= req_vector;
                s1_level  <= req_level;
                s1_group  <= req_group;
            end
        end
    end

    // Stage 2: register the selected target, path flag and bank choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_addr  <= '0;
            res_fast  <= 1'b0;
            res_bank  <= BANK_GLOBAL;
        end else begin
            res_valid <= s1_valid;
            if (s1_valid) begin
                res_addr <= fast_hit ? fast_addr : tbl_addr;
                res_fast <= fast_hit;
                res_bank <= bank_sel;
            end
        end
    end

endmodule

// File: rtl/irq_tgt_chk.sv
// Protocol and output-legality checker bound to irq_tgt_top. It tracks the
// level of the accepted request so that the matching result can be judged.
module irq_tgt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [3:0] req_level,
    input logic       res_valid,
    input logic       res_fast,
    input logic [1:0] res_bank
);

    logic [3:0] lvl_q;

    // Remember the level of the most recent accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                      lvl_q <= '0;
        else if (req_valid && req_ready) lvl_q <= req_level;
    end

    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_busy_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 res_valid);

    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_no_orphan_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(req_valid && req_ready, 2));

    p_no_rsvd_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_bank != 2'b01));

    p_low_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && lvl_q < 4'd12) |-> (res_bank == 2'b00 && !res_fast));

endmodule

bind irq_tgt_top irq_tgt_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_level(req_level),
    .res_valid(res_valid), .res_fast(res_fast), .res_bank(res_bank)
);

// File: tb/irq_tgt_top_bench.sv
// Directed bench for irq_tgt_top: one task per scenario, 200 MHz clock.
// Inputs change and outputs are sampled on the falling edge.
module irq_tgt_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_vector = '0;
    logic [3:0]  req_level = '0;
    logic [2:0]  req_group = '0;
    logic        res_valid;
    logic [23:0] res_addr;
    logic        res_fast;
    logic [1:0]  res_bank;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_tgt_top u_irq_tgt_top (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vector(req_vector), .req_level(req_level), .req_group(req_group),
        .res_valid(res_valid), .res_addr(res_addr),
        .res_fast(res_fast), .res_bank(res_bank)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] tbl(input logic [23:0] base, input int sel, input logic [7:0] vec);
        return base + (24'(vec) << (sel + 2));
    endfunction

    task automatic cfg_wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One request with full handshake and result checks.
    task automatic run_req(input string tag, input logic [7:0] vec, input logic [3:0] lvl,
                           input logic [2:0] grp, input logic [23:0] e_addr,
                           input logic e_fast, input logic [1:0] e_bank);
        @(negedge clk);
        req_valid = 1'b1; req_vector = vec; req_level = lvl; req_group = grp;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R2 ready low"}, 32'(req_ready), 32'd0);
        @(negedge clk);
        chk({tag, " R2 valid"}, 32'(res_valid), 32'd1);
        chk({tag, " addr"}, 32'(res_addr), 32'(e_addr));
        chk({tag, " fast"}, 32'(res_fast), 32'(e_fast));
        chk({tag, " bank"}, 32'(res_bank), 32'(e_bank));
        @(negedge clk);
        chk({tag, " R2 pulse end"}, 32'(res_valid), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 valid", 32'(res_valid), 32'd0);
        run_req("R1 cleared cfg", 8'd5, 4'd12, 3'd0, 24'h000014, 1'b0, 2'b00);
    endtask

    task automatic t_spacing;
        cfg_wr(4'd1, 16'h2340);
        cfg_wr(4'd2, 16'h0001);
        for (int s = 0; s < 4; s++) begin
            cfg_wr(4'd0, 16'(s));
            run_req($sformatf("R3 sel%0d", s), 8'h21, 4'd2, 3'd1,
                    tbl(24'h012340, s, 8'h21), 1'b0, 2'b00);
        end
    endtask

    task automatic t_carry;
        cfg_wr(4'd0, 16'd3);
        cfg_wr(4'd1, 16'hFFF0);
        cfg_wr(4'd2, 16'h0012);
        run_req("R4 seg carry", 8'hFF, 4'd1, 3'd0, 24'h131FD0, 1'b0, 2'b00);
        cfg_wr(4'd1, 16'hFF00);
        cfg_wr(4'd2, 16'h00FF);
        run_req("R4 wrap", 8'h10, 4'd1, 3'd0, 24'h000100, 1'b0, 2'b00);
    endtask

    task automatic t_fast;
        cfg_wr(4'd0, 16'd0);
        cfg_wr(4'd1, 16'h0000);
        cfg_wr(4'd2, 16'h0000);
        // pair 0: enabled, level 13, group 5, segment 3A, offset BEEF
        cfg_wr(4'd3, 16'h8000 | (16'd1 << 13) | (16'd5 << 10) | 16'h003A);
        cfg_wr(4'd4, 16'hBEEF);
        run_req("R5 hit", 8'd7, 4'd13, 3'd5, 24'h3ABEEF, 1'b1, 2'b00);
        run_req("R7 group miss", 8'd7, 4'd13, 3'd4, 24'h00001C, 1'b0, 2'b00);
        run_req("R7 level miss", 8'd7, 4'd14, 3'd5, 24'h00001C, 1'b0, 2'b00);
        // pair 1 matches level 15 group 0 but is disabled
        cfg_wr(4'd5, (16'd3 << 13) | 16'h0044);
        cfg_wr(4'd6, 16'h1234);
        run_req("R7 disabled", 8'd2, 4'd15, 3'd0, 24'h000008, 1'b0, 2'b00);
        run_req("R7 low level", 8'd2, 4'd1, 3'd5, 24'h000008, 1'b0, 2'b00);
    endtask

    task automatic t_priority;
        cfg_wr(4'd5, 16'h8000 | (16'd1 << 13) | (16'd5 << 10) | 16'h0055);
        cfg_wr(4'd6, 16'h1234);
        run_req("R6 pair0 wins", 8'd7, 4'd13, 3'd5, 24'h3ABEEF, 1'b1, 2'b00);
        cfg_wr(4'd3, 16'h0000);
        run_req("R6 pair1 alone", 8'd7, 4'd13, 3'd5, 24'h551234, 1'b1, 2'b00);
        cfg_wr(4'd5, 16'h0000);
    endtask

    task automatic t_bank;
        // group 2: L12=10, L13=11, L14=01, L15=00
        cfg_wr(4'd10, 16'h001E);
        run_req("R8 L12", 8'd1, 4'd12, 3'd2, 24'h000004, 1'b0, 2'b10);
        run_req("R8 L13", 8'd1, 4'd13, 3'd2, 24'h000004, 1'b0, 2'b11);
        run_req("R8 L14 rsvd", 8'd1, 4'd14, 3'd2, 24'h000004, 1'b0, 2'b00);
        run_req("R8 L15", 8'd1, 4'd15, 3'd2, 24'h000004, 1'b0, 2'b00);
        cfg_wr(4'd11, 16'h00FF);
        run_req("R9 L11", 8'd1, 4'd11, 3'd3, 24'h000004, 1'b0, 2'b00);
        run_req("R9 L0", 8'd1, 4'd0, 3'd3, 24'h000004, 1'b0, 2'b00);
        run_req("R8 L12 g3", 8'd1, 4'd12, 3'd3, 24'h000004, 1'b0, 2'b11);
    endtask

    task automatic t_cfg_timing;
        @(negedge clk);
        req_valid = 1'b1; req_vector = 8'd4; req_level = 4'd3; req_group = 3'd0;
        cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = 16'h1000;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_wdata = 16'h2000;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R10 valid", 32'(res_valid), 32'd1);
        chk("R10 addr", 32'(res_addr), 32'h001010);
    endtask

    task automatic t_stall;
        @(negedge clk);
        req_valid = 1'b1; req_vector = 8'd1; req_level = 4'd0; req_group = 3'd0;
        @(negedge clk);
        chk("R11 busy", 32'(req_ready), 32'd0);
        req_vector = 8'd9;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 first result", 32'(res_addr), 32'h002004);
        @(negedge clk);
        chk("R11 no second a", 32'(res_valid), 32'd0);
        @(negedge clk);
        chk("R11 no second b", 32'(res_valid), 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_spacing();
        t_carry();
        t_fast();
        t_priority();
        t_bank();
        t_cfg_timing();
        t_stall();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule